// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous DRAM interface. After reset it takes the memory from an unknown power-up state to one where normal traffic can begin. It first holds the clock-enable and data-mask pins high and drives no-operation commands for a stabilization pause. The pause length is set by a cycles-per-microsecond parameter and a pause length in microseconds. It then closes every bank with one precharge command. Finally it issues the mode-register load and a burst of auto-refresh commands. A parameter picks whether the refreshes come before or after the mode load.

Every command is followed by its own parameterized quiet time of no-operation cycles: a precharge wait, a refresh recovery wait and a mode-load wait. When the last of these has run out, a completion flag rises and stays high until the next reset. A reset at any point, including partway through the sequence, starts the whole bring-up again from the beginning.

Commands appear on the four active-low strobes as {cs_n, ras_n, cas_n, we_n}: no-operation is 0111, precharge is 0010, auto-refresh is 0001 and mode-register load is 0000.

Top module: `sdram_bringup_seq`

## Requirements
- R1: While reset is asserted, cke is 0, dqm is 1, the command is no-operation (0111), addr is 0 and init_done is 0.
- R2: For the first CYC_PER_US*PAUSE_US cycles after reset is released, cke and dqm are both 1.
- R3: During that pause the command pins carry only no-operation (0111) and addr is 0.
- R4: In the cycle after the pause, exactly one precharge (0010) is driven with addr bit 10 set and every other addr bit clear. dqm is 0 from that cycle on. T_RP no-operation cycles follow it.
- R5: The mode-register load (0000) is driven once, with addr equal to MODE_WORD, and only after the precharge and its T_RP wait.
- R6: REFRESH_COUNT auto-refresh commands (0001, addr 0) are driven, each followed by T_RFC no-operation cycles. With REFRESH_FIRST=1 they all come before the mode load; with REFRESH_FIRST=0 they all come after it.
- R7: cke is 1 in the mode-load cycle and was already 1 in the cycle before it.
- R8: The mode load is followed by T_MRD no-operation cycles, and always by at least one.
- R9: init_done first rises in the cycle after the last wait of the sequence ends. After that it stays 1, with no-operation on the pins, cke 1 and dqm 0, until reset.
- R10: A reset asserted at any time, whether after completion or in the middle of the sequence, returns the outputs to the R1 state. After release, the full sequence repeats from R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Memory clock enable |
| dqm | output | 1 | Data mask, held high through the pause |
| cs_n | output | 1 | Chip select strobe, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| addr | output | ADDR_W | Address pins: bit 10 selects all banks on precharge; mode word on mode load |
| init_done | output | 1 | High once bring-up is complete |

## Verification
The hardest situation to reach from the ports is a reset that lands partway through the command phase. By then the precharge has been issued and the refresh or mode-load bookkeeping is half done, yet the restart must still produce a full pause and a fresh precharge. The bench releases reset and counts cycles, then pulls reset again after a fixed number of cycles chosen to fall after the precharge. From that point it compares the restarted run against a freshly built expected trace. Two instances run side by side with the two refresh orderings, so both placements of the mode load are compared cycle by cycle against the same reference model.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Command strobes as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001,
        CMD_MRS = 4'b0000
    } cmd_e;

    typedef enum logic [1:0] {
        ST_RST   = 2'd0,
        ST_PAUSE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } st_e;

endpackage

// File: rtl/initseq_timer.sv
module initseq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

    // R2
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/initseq_order.sv
module initseq_order
    import sdram_init_pkg::*;
#(
    parameter int REF_N     = 8,
    parameter int REF_FIRST = 0,
    parameter int RC_W      = 4
) (
    input  logic            pre_done,
    input  logic            mrs_done,
    input  logic [RC_W-1:0] ref_cnt,
    output cmd_e            nxt_cmd,
    output logic            finished
);
    logic refs_full;

    assign refs_full = (ref_cnt == RC_W'(REF_N));
    assign finished  = pre_done && mrs_done && refs_full;

    generate
        if (REF_FIRST != 0) begin : g_ref_first
            always_comb begin
                if (!pre_done) begin
                    nxt_cmd = CMD_PRE;
                end else if (!refs_full) begin
                    nxt_cmd = CMD_REF;
                end else begin
                    nxt_cmd = CMD_MRS;
                end
            end
        end else begin : g_mrs_first
            always_comb begin
                if (!pre_done) begin
                    nxt_cmd = CMD_PRE;
                end else if (!mrs_done) begin
                    nxt_cmd = CMD_MRS;
                end else begin
                    nxt_cmd = CMD_REF;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/initseq_pins.sv
module initseq_pins
    import sdram_init_pkg::*;
#(
    parameter int                ADDR_W    = 13,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
    input  cmd_e              cmd,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr
);
    localparam int ALLBANK_BIT = 10;

    assign {cs_n, ras_n, cas_n, we_n} = cmd;

    always_comb begin
        unique case (cmd)
            CMD_PRE: addr = ADDR_W'(1) << ALLBANK_BIT;
            CMD_MRS: addr = MODE_WORD;
            default: addr = '0;
        endcase
    end

endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq
    import sdram_init_pkg::*;
#(
    parameter int                CYC_PER_US    = 100,
    parameter int                PAUSE_US      = 200,
    parameter int                T_RP          = 3,
    parameter int                T_RFC         = 9,
    parameter int                T_MRD         = 2,
    parameter int                REFRESH_COUNT = 8,
    parameter int                REFRESH_FIRST = 0,
    parameter int                ADDR_W        = 13,
    parameter logic [ADDR_W-1:0] MODE_WORD     = 13'h0032
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cke,
    output logic              dqm,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int PAUSE_CYC = (CYC_PER_US * PAUSE_US < 1) ? 1 : CYC_PER_US * PAUSE_US;
    localparam int RP_CYC    = (T_RP  < 1) ? 1 : T_RP;
    localparam int RFC_CYC   = (T_RFC < 1) ? 1 : T_RFC;
    localparam int MRD_CYC   = (T_MRD < 1) ? 1 : T_MRD;
    localparam int MAX_A     = (RP_CYC > RFC_CYC) ? RP_CYC : RFC_CYC;
    localparam int MAX_B     = (MAX_A > MRD_CYC) ? MAX_A : MRD_CYC;
    localparam int MAX_W     = (PAUSE_CYC > MAX_B) ? PAUSE_CYC : MAX_B;
    localparam int CNT_W     = $clog2(MAX_W + 1);
    localparam int RC_W      = $clog2(REFRESH_COUNT + 1);

    typedef struct packed {
        st_e             st;
        cmd_e            cmd;
        logic            cke;
        logic            dqm;
        logic            done;
        logic            pre_done;
        logic            mrs_done;
        logic [RC_W-1:0] ref_cnt;
    } regs_t;

    localparam regs_t R_INIT = '{
        st:       ST_RST,
        cmd:      CMD_NOP,
        cke:      1'b0,
        dqm:      1'b1,
        done:     1'b0,
        pre_done: 1'b0,
        mrs_done: 1'b0,
        ref_cnt:  '0
    };

    regs_t            r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    cmd_e             nxt_cmd;
    logic             finished;

    initseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    initseq_order #(
        .REF_N     (REFRESH_COUNT),
        .REF_FIRST (REFRESH_FIRST),
        .RC_W      (RC_W)
    ) u_order (
        .pre_done (r_q.pre_done),
        .mrs_done (r_q.mrs_done),
        .ref_cnt  (r_q.ref_cnt),
        .nxt_cmd  (nxt_cmd),
        .finished (finished)
    );

    initseq_pins #(
        .ADDR_W    (ADDR_W),
        .MODE_WORD (MODE_WORD)
    ) u_pins (
        .cmd   (r_q.cmd),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .addr  (addr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.cmd  = CMD_NOP;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_RST: begin
                r_d.st   = ST_PAUSE;
                r_d.cke  = 1'b1;
                r_d.dqm  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(PAUSE_CYC - 1);
            end
            ST_PAUSE, ST_WAIT: begin
                if (tmr_zero) begin
                    if (finished) begin
                        r_d.st   = ST_DONE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st   = ST_WAIT;
                        r_d.cmd  = nxt_cmd;
                        r_d.dqm  = 1'b0;
                        tmr_load = 1'b1;
                        unique case (nxt_cmd)
                            CMD_PRE: begin
                                r_d.pre_done = 1'b1;
                                tmr_val      = CNT_W'(RP_CYC);
                            end
                            CMD_REF: begin
                                r_d.ref_cnt = r_q.ref_cnt + RC_W'(1);
                                tmr_val     = CNT_W'(RFC_CYC);
                            end
                            CMD_MRS: begin
                                r_d.mrs_done = 1'b1;
                                tmr_val      = CNT_W'(MRD_CYC);
                            end
                            default: begin
                                tmr_val = '0;
                            end
                        endcase
                    end
                end
            end
            ST_DONE: begin
                r_d.st = ST_DONE;
            end
            default: begin
                r_d = R_INIT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= R_INIT;
        end else begin
            r_q <= r_d;
        end
    end

    assign cke       = r_q.cke;
    assign dqm       = r_q.dqm;
    assign init_done = r_q.done;

    logic [3:0] cmd_pins;
    assign cmd_pins = {cs_n, ras_n, cas_n, we_n};

    // R3
    pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PAUSE) |-> (cmd_pins == 4'b0111 && cke && dqm));

    // R4
    pre_allbank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pins == 4'b0010) |-> (addr == (ADDR_W'(1) << 10)));

    // R5
    mrs_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pins == 4'b0000) |-> (r_q.pre_done && $past(cmd_pins) == 4'b0111));

    // R7
    cke_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pins == 4'b0000) |-> (cke && $past(cke)));

    // R8
    mrs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pins == 4'b0000) |=> (cmd_pins == 4'b0111));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (init_done && cmd_pins == 4'b0111));

    // R6
    ref_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (r_q.ref_cnt == RC_W'(REFRESH_COUNT)));

    generate
        if (REFRESH_FIRST != 0) begin : g_chk_ref_first
            // R6
            ref_before_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_pins == 4'b0000) |-> (r_q.ref_cnt == RC_W'(REFRESH_COUNT)));
        end else begin : g_chk_mrs_first
            // R6
            ref_after_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_pins == 4'b0001) |-> r_q.mrs_done);
        end
    endgenerate

endmodule

// File: tb/sim_sdram_bringup_seq.sv
`timescale 1ns/1ps
module sim_sdram_bringup_seq;
    localparam int CPU  = 5;
    localparam int PUS  = 200;
    localparam int TRP  = 2;
    localparam int TRFC = 6;
    localparam int TMRD = 2;
    localparam int NREF = 8;
    localparam int AW   = 13;
    localparam logic [AW-1:0] MW0 = 13'h00A3;
    localparam logic [AW-1:0] MW1 = 13'h0137;
    localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic cke0, dqm0, cs0, ras0, cas0, we0, dn0;
    logic cke1, dqm1, cs1, ras1, cas1, we1, dn1;
    logic [AW-1:0] a0, a1;

    sdram_bringup_seq #(.CYC_PER_US(CPU), .PAUSE_US(PUS), .T_RP(TRP), .T_RFC(TRFC),
        .T_MRD(TMRD), .REFRESH_COUNT(NREF), .REFRESH_FIRST(0), .ADDR_W(AW),
        .MODE_WORD(MW0)) u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke0), .dqm(dqm0), .cs_n(cs0), .ras_n(ras0),
        .cas_n(cas0), .we_n(we0), .addr(a0), .init_done(dn0));

    sdram_bringup_seq #(.CYC_PER_US(CPU), .PAUSE_US(PUS), .T_RP(TRP), .T_RFC(TRFC),
        .T_MRD(TMRD), .REFRESH_COUNT(NREF), .REFRESH_FIRST(1), .ADDR_W(AW),
        .MODE_WORD(MW1)) u1 (
        .clk(clk), .rst_n(rst_n), .cke(cke1), .dqm(dqm1), .cs_n(cs1), .ras_n(ras1),
        .cas_n(cas1), .we_n(we1), .addr(a1), .init_done(dn1));

    typedef struct {
        logic [3:0]    cmd;
        logic [AW-1:0] addr;
        logic          cke;
        logic          dqm;
        logic          done;
        string         tag;
    } exp_t;

    exp_t q0[$];
    exp_t q1[$];
    exp_t tq[$];
    int   errors = 0;
    int   checks = 0;
    bit   ended  = 1'b0;

    task automatic push(input logic [3:0] c, input logic [AW-1:0] a, input logic ck,
                        input logic dq, input string t, input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.cmd = c; e.addr = a; e.cke = ck; e.dqm = dq; e.done = 1'b0; e.tag = t;
            tq.push_back(e);
        end
    endtask

    task automatic push_refs();
        for (int i = 0; i < NREF; i++) begin
            push(REF, '0, 1'b1, 1'b0, "R6", 1);
            push(NOP, '0, 1'b1, 1'b0, "R6", TRFC);
        end
    endtask

    task automatic push_mrs(input logic [AW-1:0] mw);
        push(MRS, mw, 1'b1, 1'b0, "R5", 1);
        push(NOP, '0, 1'b1, 1'b0, "R8", TMRD);
    endtask

    task automatic build(input bit rf, input logic [AW-1:0] mw);
        tq.delete();
        push(NOP, '0, 1'b1, 1'b1, "R2 R3", CPU * PUS);
        push(PRE, 13'h0400, 1'b1, 1'b0, "R4", 1);
        push(NOP, '0, 1'b1, 1'b0, "R4", TRP);
        if (rf) begin
            push_refs();
            push_mrs(mw);
        end else begin
            push_mrs(mw);
            push_refs();
        end
    endtask

    task automatic cmp(input int u, input int cyc, input exp_t e, input logic [3:0] c,
                       input logic [AW-1:0] a, input logic ck, input logic dq, input logic dn);
        string t;
        checks++;
        if (c !== e.cmd || a !== e.addr || ck !== e.cke || dq !== e.dqm || dn !== e.done) begin
            errors++;
            t = e.tag;
            if (e.cmd == MRS && ck !== e.cke) t = "R7";
            $display("FAIL %s u%0d cycle %0d: got cmd=%b addr=%h cke=%b dqm=%b done=%b, expected cmd=%b addr=%h cke=%b dqm=%b done=%b",
                     t, u, cyc, c, a, ck, dq, dn, e.cmd, e.addr, e.cke, e.dqm, e.done);
        end
    endtask

    task automatic check_reset(input string t);
        exp_t e;
        e.cmd = NOP; e.addr = '0; e.cke = 1'b0; e.dqm = 1'b1; e.done = 1'b0; e.tag = t;
        cmp(0, 0, e, {cs0, ras0, cas0, we0}, a0, cke0, dqm0, dn0);
        cmp(1, 0, e, {cs1, ras1, cas1, we1}, a1, cke1, dqm1, dn1);
    endtask

    task automatic run(input int n);
        exp_t fin;
        fin.cmd = NOP; fin.addr = '0; fin.cke = 1'b1; fin.dqm = 1'b0; fin.done = 1'b1; fin.tag = "R9";
        for (int i = 1; i <= n; i++) begin
            @(posedge clk);
            @(negedge clk);
            cmp(0, i, (i <= q0.size()) ? q0[i-1] : fin, {cs0, ras0, cas0, we0}, a0, cke0, dqm0, dn0);
            cmp(1, i, (i <= q1.size()) ? q1[i-1] : fin, {cs1, ras1, cas1, we1}, a1, cke1, dqm1, dn1);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset("R1");
        build(1'b0, MW0); q0 = tq;
        build(1'b1, MW1); q1 = tq;
        // full bring-up in both orders, then hold after completion (R9)
        rst_n = 1'b1;
        run(q0.size() + 30);
        // reset after completion (R10)
        rst_n = 1'b0;
        @(negedge clk);
        check_reset("R10");
        @(negedge clk);
        rst_n = 1'b1;
        // stop inside the command phase, after the precharge (R10)
        run(CPU * PUS + 20);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset("R10");
        @(negedge clk);
        rst_n = 1'b1;
        run(q0.size() + 30);
        ended = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule